// File: doc/BRIEF.md
# Fractional Clock Divider with Phase Accumulator

This block derives a slower clock from its input clock at a ratio that need not be an integer. A base divisor gives two period lengths per output cycle, a short one and a long one. A 32-bit phase accumulator picks between them once per output cycle, and the same accumulator bit picks which of two programmed increments is added. Over many output cycles the average ratio can be set to a fine resolution.

The coarse part of the divisor is counted by an 11-bit Galois shift-register counter. Software therefore writes the coarse count as a shift-register state, not as a binary number. The fine part and the accumulator's long-period request together add zero to two whole input cycles to a short head segment. An odd effective divisor asks for a half cycle, which the block gives by alternating the floor and ceiling counts, so all logic runs on one clock edge.

Configuration is held in shadow registers. It moves into the working set only while the channel is disabled. Software disables the channel, programs the divisor, both increments and the seed, then enables it again. Writes made while the channel runs wait until the next enable.

Top module: `nco_frac_div`

## Requirements
- R1: After reset the channel is disabled and clk_out is low.
- R2: A write to byte offset 0x00 with bit 31 set enables the channel, and clk_out is high in the first cycle after that write's clock edge. A write there with bit 31 clear disables the channel.
- R3: The divisor word sits at offset 0x04, with fine value f in bits [1:0] and coarse code c in bits [12:2]. Code 0 means k=0. Any other code c means k is the number of states from c up to and including all-ones under the step s -> (s>>1) XOR (s[0] ? 0x500 : 0). The base divisor is D = 4(k+2)+f. While accumulator bit 31 stays clear and D is even, every output period lasts D/2 input cycles (k=0,f=0 gives 4; k=1 gives 6).
- R4: During a period whose accumulator bit 31 is set, the effective divisor is D+1.
- R5: When the effective divisor is odd, the period takes the floor and the ceiling of half of it in turn. The first odd period after enable takes the floor, and periods with an even divisor do not disturb the alternation.
- R6: On enable the accumulator takes the seed word at offset 0x10. At the end of each period it adds the word at 0x08 when bit 31 is clear, or the word at 0x0C when bit 31 is set, modulo 2^32. The bit-31 value that picks the increment is the one that governed the period just ended.
- R7: clk_out is high for the first 2 input cycles of each output period and low for the rest.
- R8: After bit 31 of 0x00 is cleared, clk_out is low from the next cycle. Re-enabling starts a new period with the accumulator back at the seed and the alternation back at floor.
- R9: Writes to offsets 0x04 to 0x10 while the channel is enabled do not change the output. They take effect at the next enable.
- R10: With i1 below 2^31 and i2 at or above 2^31 (two's complement), the output-to-input frequency ratio is 2(i1-i2)/(D(i1-i2)+i1), within 2 edges over 20000 input cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Byte offset of the register written |
| wr_data | input | 32 | Write data |
| clk_out | output | 1 | Divided clock |

## Verification
The bench goes after the ends of the coarse range. Code 0 must yield a 4-cycle period; a decoder that treated 0 as a shift-register state would hang or stretch it. Code all-ones must yield 6 cycles; an off-by-one in the terminal test gives 4 or 8. Odd effective divisors must alternate starting with the floor, or a period pattern comes out rotated or constant. An accumulator that added the wrong increment, or switched on the updated bit instead of the current one, shows up as a shifted position for the stretched period and a long-run edge count off the ratio formula. Writes made while running, and a disable followed by a re-enable, are checked for a frozen configuration and a restart from the seed.

// File: rtl/nco_pkg.sv
package nco_pkg;
   // byte offsets of the channel registers
   localparam int OFS_CTRL    = 'h00;
   localparam int OFS_DIVISOR = 'h04;
   localparam int OFS_INC_CLR = 'h08;
   localparam int OFS_INC_SET = 'h0C;
   localparam int OFS_SEED    = 'h10;

   typedef enum logic {
      PH_HEAD   = 1'b0,
      PH_COARSE = 1'b1
   } nco_phase_e;
endpackage

// File: rtl/nco_cfg_regs.sv
module nco_cfg_regs
   import nco_pkg::*;
#(
   parameter int ACC_W  = 32,
   parameter int CODE_W = 11,
   parameter int FINE_W = 2,
   parameter int ADDR_W = 5
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [ACC_W-1:0]  wr_data,
   output logic              run,
   output logic [CODE_W-1:0] code,
   output logic [FINE_W-1:0] fine,
   output logic [ACC_W-1:0]  inc_clr,
   output logic [ACC_W-1:0]  inc_set,
   output logic [ACC_W-1:0]  seed_nxt
);
   localparam int EN_BIT = ACC_W - 1;

   logic [CODE_W-1:0] sh_code;
   logic [FINE_W-1:0] sh_fine;
   logic [ACC_W-1:0]  sh_clr, sh_set, sh_seed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run     <= 1'b0;
         sh_code <= '0;
         sh_fine <= '0;
         sh_clr  <= '0;
         sh_set  <= '0;
         sh_seed <= '0;
         code    <= '0;
         fine    <= '0;
         inc_clr <= '0;
         inc_set <= '0;
      end else begin
         if (wr_en) begin
            if (wr_addr == ADDR_W'(OFS_CTRL))    run <= wr_data[EN_BIT];
            if (wr_addr == ADDR_W'(OFS_DIVISOR)) begin
               sh_fine <= wr_data[FINE_W-1:0];
               sh_code <= wr_data[FINE_W +: CODE_W];
            end
            if (wr_addr == ADDR_W'(OFS_INC_CLR)) sh_clr  <= wr_data;
            if (wr_addr == ADDR_W'(OFS_INC_SET)) sh_set  <= wr_data;
            if (wr_addr == ADDR_W'(OFS_SEED))    sh_seed <= wr_data;
         end
         // the working set follows the shadows only while stopped
         if (!run) begin
            code    <= sh_code;
            fine    <= sh_fine;
            inc_clr <= sh_clr;
            inc_set <= sh_set;
         end
      end
   end

   assign seed_nxt = sh_seed;
endmodule

// File: rtl/nco_lfsr_cnt.sv
module nco_lfsr_cnt #(
   parameter int             W    = 11,
   parameter logic [W-1:0]   TAPS = 11'h500
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         step,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] state
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    state <= '0;
      else if (load) state <= load_val;
      else if (step) state <= state[0] ? ((state >> 1) ^ TAPS) : (state >> 1);
   end
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
   parameter int ACC_W  = 32,
   parameter int FINE_W = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              period_end,
   input  logic [FINE_W-1:0] fine,
   input  logic [ACC_W-1:0]  seed,
   input  logic [ACC_W-1:0]  inc_clr,
   input  logic [ACC_W-1:0]  inc_set,
   output logic              long_sel,
   output logic              half
);
   logic [ACC_W-1:0] acc;

   assign long_sel = acc[ACC_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc  <= '0;
         half <= 1'b0;
      end else if (!run) begin
         acc  <= seed;
         half <= 1'b0;
      end else if (period_end) begin
         acc <= acc + (long_sel ? inc_set : inc_clr);
         // an odd effective divisor flips the floor/ceiling choice
         if (fine[0] ^ long_sel) half <= ~half;
      end
   end
endmodule

// File: rtl/nco_frac_div.sv
module nco_frac_div
   import nco_pkg::*;
#(
   parameter int                ACC_W      = 32,
   parameter int                CODE_W     = 11,
   parameter int                FINE_W     = 2,
   parameter int                ADDR_W     = 5,
   parameter logic [CODE_W-1:0] LFSR_TAPS  = CODE_W'(11'h500),
   parameter int                COARSE_MIN = 2,
   parameter int                HIGH_CYC   = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [ACC_W-1:0]  wr_data,
   output logic              clk_out
);
   localparam int SUB_W     = FINE_W - 1;
   localparam int STEP_CYC  = 1 << SUB_W;
   localparam int HEAD_BASE = COARSE_MIN * STEP_CYC;
   localparam int CNT_W     = $clog2(HEAD_BASE + STEP_CYC);

   generate
      if (FINE_W < 2)                     begin : g_bad_fine  $error("FINE_W must be at least 2"); end
      if (CODE_W + FINE_W > ACC_W - 1)    begin : g_bad_code  $error("divisor fields overlap enable bit"); end
      if (COARSE_MIN < 1)                 begin : g_bad_min   $error("COARSE_MIN must be positive"); end
      if (HIGH_CYC < 1 || HIGH_CYC >= HEAD_BASE) begin : g_bad_high $error("HIGH_CYC out of range"); end
      if (ADDR_W < 5)                     begin : g_bad_addr  $error("ADDR_W too narrow for map"); end
   endgenerate

   logic              run;
   logic [CODE_W-1:0] code;
   logic [FINE_W-1:0] fine;
   logic [ACC_W-1:0]  inc_clr, inc_set, seed_nxt;
   logic              long_sel, half;
   logic [CODE_W-1:0] lfsr_state;

   nco_phase_e        phase_q;
   logic [CNT_W-1:0]  hcnt;
   logic [SUB_W-1:0]  sub;
   logic [FINE_W:0]   dsum;
   logic [CNT_W-1:0]  head_last;
   logic              in_coarse, at_term, head_done, coarse_done;
   logic              period_end, lfsr_load, lfsr_step;

   nco_cfg_regs #(.ACC_W(ACC_W), .CODE_W(CODE_W), .FINE_W(FINE_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .run(run), .code(code), .fine(fine), .inc_clr(inc_clr), .inc_set(inc_set),
      .seed_nxt(seed_nxt)
   );

   nco_phase_acc #(.ACC_W(ACC_W), .FINE_W(FINE_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .run(run), .period_end(period_end), .fine(fine),
      .seed(seed_nxt), .inc_clr(inc_clr), .inc_set(inc_set),
      .long_sel(long_sel), .half(half)
   );

   nco_lfsr_cnt #(.W(CODE_W), .TAPS(LFSR_TAPS)) u_lfsr (
      .clk(clk), .rst_n(rst_n), .load(lfsr_load), .step(lfsr_step),
      .load_val(code), .state(lfsr_state)
   );

   // head length: base plus floor or ceiling of (fine + long request)/2
   assign dsum      = {1'b0, fine} + {{FINE_W{1'b0}}, long_sel};
   assign head_last = CNT_W'(HEAD_BASE - 1) + CNT_W'(dsum >> 1) + CNT_W'(dsum[0] & half);

   always_comb begin
      in_coarse   = (phase_q == PH_COARSE);
      at_term     = &lfsr_state;
      head_done   = !in_coarse && (hcnt == head_last);
      coarse_done = in_coarse && (&sub) && at_term;
      period_end  = run && ((head_done && (code == '0)) || coarse_done);
      lfsr_load   = run && head_done && (code != '0);
      lfsr_step   = run && in_coarse && (&sub) && !at_term;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_HEAD;
         hcnt    <= '0;
         sub     <= '0;
      end else if (!run) begin
         phase_q <= PH_HEAD;
         hcnt    <= '0;
         sub     <= '0;
      end else if (!in_coarse) begin
         if (head_done) begin
            hcnt <= '0;
            sub  <= '0;
            if (code != '0) phase_q <= PH_COARSE;
         end else begin
            hcnt <= hcnt + 1'b1;
         end
      end else begin
         sub <= sub + 1'b1;
         if (coarse_done) phase_q <= PH_HEAD;
      end
   end

   assign clk_out = run && !in_coarse && (hcnt < CNT_W'(HIGH_CYC));
endmodule

// File: rtl/nco_frac_div_chk.sv
module nco_frac_div_chk #(
   parameter int CODE_W  = 11,
   parameter int FINE_W  = 2,
   parameter int ACC_W   = 32,
   parameter int MIN_PER = 4
)(
   input logic              clk,
   input logic              rst_n,
   input logic              run,
   input logic              clk_out,
   input logic              period_end,
   input logic              long_sel,
   input logic              half,
   input logic              in_coarse,
   input logic [CODE_W-1:0] lfsr_state,
   input logic [CODE_W-1:0] code,
   input logic [FINE_W-1:0] fine,
   input logic [ACC_W-1:0]  inc_clr,
   input logic [ACC_W-1:0]  inc_set
);
   logic        out_d, seen;
   logic [15:0] since;
   logic        rise;

   assign rise = clk_out && !out_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_d <= 1'b0;
         seen  <= 1'b0;
         since <= '0;
      end else begin
         out_d <= clk_out;
         if (!run)                since <= '0;
         else if (rise)           since <= 16'd1;
         else if (since != '1)    since <= since + 16'd1;
         if (!run)      seen <= 1'b0;
         else if (rise) seen <= 1'b1;
      end
   end

   // R2: first enabled cycle starts a high phase
   a_r2_first_high: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run) |-> clk_out);

   // R3: the coarse counter never sits in the stuck all-zero state while counting
   a_r3_lfsr_live: assert property (@(posedge clk) disable iff (!rst_n)
      in_coarse |-> (lfsr_state != '0));

   // R6: accumulator state moves only at a period boundary
   a_r6_acc_steady: assert property (@(posedge clk) disable iff (!rst_n)
      run && $past(run) && !$past(period_end) |-> $stable(long_sel) && $stable(half));

   // R7: two rising edges are never closer than the shortest period
   a_r7_min_period: assert property (@(posedge clk) disable iff (!rst_n)
      rise && seen |-> since >= 16'(MIN_PER));

   // R9: working configuration frozen while running
   a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      run && $past(run) |-> $stable(code) && $stable(fine) && $stable(inc_clr) && $stable(inc_set));
endmodule

bind nco_frac_div nco_frac_div_chk #(
   .CODE_W(CODE_W), .FINE_W(FINE_W), .ACC_W(ACC_W), .MIN_PER(HEAD_BASE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .run(run), .clk_out(clk_out), .period_end(period_end),
   .long_sel(long_sel), .half(half), .in_coarse(in_coarse), .lfsr_state(lfsr_state),
   .code(code), .fine(fine), .inc_clr(inc_clr), .inc_set(inc_set)
);

// File: tb/test_nco_frac_div.sv
module test_nco_frac_div;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [4:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        clk_out;

   nco_frac_div i_nco_frac_div (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .clk_out(clk_out)
   );

   always #2 clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;
   int cyc = 0;
   int rises[$];
   bit prev_o = 1'b0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [10:0] lfsr_next(input logic [10:0] s);
      return s[0] ? ((s >> 1) ^ 11'h500) : (s >> 1);
   endfunction

   function automatic logic [10:0] code_of(input int k);
      logic [10:0] s;
      s = 11'h7ff;
      if (k == 0) return 11'h0;
      for (int i = 0; i < 2048 - k; i++) s = lfsr_next(s);
      return s;
   endfunction

   function automatic int k_of(input logic [10:0] c);
      logic [10:0] s;
      int n;
      if (c == 11'h0) return 0;
      s = c;
      n = 1;
      while (s != 11'h7ff && n < 4096) begin
         s = lfsr_next(s);
         n++;
      end
      return n;
   endfunction

   // behavioural reference model
   bit          m_en, m_half, msb;
   int          m_k, m_f, sh_k, sh_f, m_cnt;
   logic [31:0] m_i1, m_i2, m_acc, sh_i1, sh_i2, sh_seed;

   function automatic int m_len();
      int d;
      d = m_f + int'(m_acc[31]);
      return 2 * m_k + 4 + d / 2 + (((d % 2) == 1 && m_half) ? 1 : 0);
   endfunction

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_en = 0; m_half = 0; m_k = 0; m_f = 0; sh_k = 0; sh_f = 0; m_cnt = 0;
         m_i1 = 0; m_i2 = 0; m_acc = 0; sh_i1 = 0; sh_i2 = 0; sh_seed = 0;
      end else begin
         if (!m_en) begin
            m_k = sh_k; m_f = sh_f; m_i1 = sh_i1; m_i2 = sh_i2;
            m_acc = sh_seed; m_cnt = 0; m_half = 0;
         end else if (m_cnt == m_len() - 1) begin
            msb = m_acc[31];
            if (((m_f + int'(msb)) % 2) == 1) m_half = !m_half;
            m_acc = m_acc + (msb ? m_i2 : m_i1);
            m_cnt = 0;
         end else begin
            m_cnt++;
         end
         if (wr_en) begin
            case (wr_addr)
               5'h00: m_en = wr_data[31];
               5'h04: begin sh_f = int'(wr_data[1:0]); sh_k = k_of(wr_data[12:2]); end
               5'h08: sh_i1 = wr_data;
               5'h0C: sh_i2 = wr_data;
               5'h10: sh_seed = wr_data;
               default: ;
            endcase
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         // R7 waveform, with R3..R6 period lengths, compared each cycle
         chk(clk_out === (m_en && m_cnt < 2), "R7 cycle model", longint'(clk_out),
             longint'(m_en && m_cnt < 2));
         if (clk_out && !prev_o) rises.push_back(cyc);
         prev_o = clk_out;
      end
   end

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic setup(input int k, input int f, input logic [31:0] i1,
                        input logic [31:0] i2, input logic [31:0] seed);
      wr(5'h00, 32'h0);
      wr(5'h04, {19'b0, code_of(k), 2'(f)});
      wr(5'h08, i1);
      wr(5'h0C, i2);
      wr(5'h10, seed);
   endtask

   task automatic start();
      rises.delete();
      wr(5'h00, 32'h8000_0000);
      chk(clk_out === 1'b1, "R2 high on first enabled cycle", longint'(clk_out), 1);
   endtask

   function automatic int gap(input int i);
      if (rises.size() < i + 2) return -1;
      return rises[i+1] - rises[i];
   endfunction

   task automatic finish_up();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog all-requirements actual=%0d expected=%0d", 200000, 0);
         finish_up();
      end
   end

   initial begin
      bit all_low;
      longint expn;
      repeat (4) @(negedge clk);
      chk(clk_out === 1'b0, "R1 low in reset", longint'(clk_out), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(clk_out === 1'b0, "R1 low after reset", longint'(clk_out), 0);

      // R3: smallest code gives 4-cycle periods
      setup(0, 0, 32'h0, 32'h0, 32'h0);
      start();
      repeat (30) @(negedge clk);
      chk(gap(0) == 4 && gap(1) == 4, "R3 code zero period", gap(1), 4);

      // R3: all-ones code is k=1, 6 cycles
      setup(1, 0, 32'h0, 32'h0, 32'h0);
      start();
      repeat (30) @(negedge clk);
      chk(gap(0) == 6 && gap(2) == 6, "R3 terminal code period", gap(0), 6);

      // R3: k=3 gives D=20, 10 cycles
      setup(3, 0, 32'h0, 32'h0, 32'h0);
      start();
      repeat (40) @(negedge clk);
      chk(gap(0) == 10 && gap(1) == 10, "R3 even divisor period", gap(0), 10);

      // R4: bit 31 set lengthens D=21 to 22 -> 11 cycles
      setup(3, 1, 32'h0, 32'h0, 32'h8000_0000);
      start();
      repeat (50) @(negedge clk);
      chk(gap(0) == 11 && gap(1) == 11, "R4 long period", gap(0), 11);

      // R5: D=21 odd alternates 10, 11 starting with floor
      setup(3, 1, 32'h0, 32'h0, 32'h0);
      start();
      repeat (60) @(negedge clk);
      chk(gap(0) == 10, "R5 first odd period floor", gap(0), 10);
      chk(gap(1) == 11 && gap(2) == 10, "R5 alternation", gap(1), 11);

      // R6: accumulator walk gives periods 10,10,10,10,11
      setup(3, 0, 32'h4000_0000, 32'hC000_0000, 32'h0);
      start();
      repeat (80) @(negedge clk);
      chk(gap(3) == 10, "R6 increment select short", gap(3), 10);
      chk(gap(4) == 11, "R6 increment select long", gap(4), 11);

      // R8: disable forces low, re-enable restarts from the seed
      wr(5'h00, 32'h0);
      all_low = 1'b1;
      for (int i = 0; i < 10; i++) begin
         if (clk_out !== 1'b0) all_low = 1'b0;
         @(negedge clk);
      end
      chk(all_low, "R8 low while disabled", longint'(all_low), 1);
      start();
      repeat (80) @(negedge clk);
      chk(gap(3) == 10 && gap(4) == 11, "R8 restart from seed", gap(4), 11);

      // R9: divisor write while running is held back
      setup(3, 0, 32'h0, 32'h0, 32'h0);
      start();
      wr(5'h04, {19'b0, code_of(5), 2'b00});
      rises.delete();
      repeat (50) @(negedge clk);
      chk(gap(0) == 10 && gap(1) == 10, "R9 write ignored while enabled", gap(0), 10);
      wr(5'h00, 32'h0);
      start();
      repeat (50) @(negedge clk);
      chk(gap(0) == 14 && gap(1) == 14, "R9 write applied on enable", gap(0), 14);

      // R10: long-run ratio, D=28, i1=40, i2=-30
      setup(5, 0, 32'd40, 32'hFFFF_FFE2, 32'h8000_0000);
      start();
      repeat (20000 - 1) @(negedge clk);
      expn = (64'd20000 * 2 * 70) / (64'd28 * 70 + 40);
      chk(rises.size() >= expn - 2 && rises.size() <= expn + 2, "R10 average ratio",
          rises.size(), expn);

      done = 1'b1;
      finish_up();
   end
endmodule